// File: doc/BRIEF.md
# Burst Palette RAM Update Port

This block holds a 256-entry color table of 16-bit words and gives a processor a single write address through which to load it. The processor first writes a header word naming the first table index and how many color words follow. The data words that follow land in consecutive table entries, and the index rolls over from the last entry back to entry 0. Once the announced number of words has arrived, the port waits for a new header.

A read strobe on the same port returns a status word whose lowest bit shows whether a burst is still open. A separate read port, meant for the video scan logic, fetches a color by index with one clock of latency. The storage is a plain simple-dual-port memory, so it maps onto one block RAM.

Top module: `pal_update_port`

## Requirements
- R1: After a synchronous reset the port waits for a header: the status word reads 0 and the first write is taken as a header.
- R2: A header word carries the start index in bits 15:8 and the number of data words to follow in bits 7:0.
- R3: The data words after a header are stored at the start index, then at each next index in turn.
- R4: When a burst runs past entry 255, the index wraps to entry 0 and the burst continues there.
- R5: A header with a count of 0 stores nothing, and the next write is taken as a new header.
- R6: After exactly the counted number of data words, the next write is taken as a header and not stored as a color.
- R7: A status read returns its word on `cpu_rdata` one clock after `cpu_rd_en`; bit 0 is 1 while a burst has words still to come and 0 otherwise, bits 15:1 are 0, and a read does not change the burst.
- R8: `vid_color` shows the table entry selected by `vid_idx` one clock after the index is presented.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Write strobe for the port address |
| cpu_wdata | input | 16 | Header or color data word |
| cpu_rd_en | input | 1 | Status read strobe |
| cpu_rdata | output | 16 | Registered status word |
| vid_idx | input | 8 | Color index from the video logic |
| vid_color | output | 16 | Registered color for `vid_idx` |

## Verification
A wrong write pointer or word counter shows first in the status bit, which drops too early or too late within one write of the fault, and then in the table contents, where a color appears at a shifted index or a header value is stored as a color. The bench reads the whole table back through the video port after every few bursts, so a misplaced word is seen within a few hundred clocks. A status word that lags or leads the burst is seen on the first read after the header or the last data word.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Whether the port expects a header or streams color words
  typedef enum logic {
    PAL_WAIT_HDR = 1'b0,
    PAL_STREAM   = 1'b1
  } pal_mode_e;
endpackage

// File: rtl/pal_color_ram.sv
module pal_color_ram #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_burst_ctrl.sv
module pal_burst_ctrl
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_waddr,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam int CNT_W = DATA_W - IDX_W;

  pal_mode_e        mode;
  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] remain;
  logic [IDX_W-1:0] hdr_idx;
  logic [CNT_W-1:0] hdr_cnt;

  assign hdr_idx   = wdata[DATA_W-1 -: IDX_W];
  assign hdr_cnt   = wdata[CNT_W-1:0];
  assign busy      = (mode == PAL_STREAM);
  assign ram_we    = wr_en && busy;
  assign ram_waddr = ptr;
  assign ram_wdata = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= PAL_WAIT_HDR;
      ptr    <= '0;
      remain <= '0;
    end else if (wr_en) begin
      if (mode == PAL_WAIT_HDR) begin
        ptr    <= hdr_idx;
        remain <= hdr_cnt;
        mode   <= (hdr_cnt != '0) ? PAL_STREAM : PAL_WAIT_HDR;
      end else begin
        ptr    <= ptr + 1'b1;
        remain <= remain - 1'b1;
        mode   <= (remain != CNT_W'(1)) ? PAL_STREAM : PAL_WAIT_HDR;
      end
    end
  end

  // R5
  zero_len_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wdata[CNT_W-1:0] == '0) |=> !busy);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> (ptr == $past(ptr) + 1'b1));

  // R6
  remain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> (remain == $past(remain) - 1'b1));

  // R6
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(wr_en) && $past(remain) == CNT_W'(1)));

  // R2
  hdr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |=> (ptr == $past(wdata[DATA_W-1 -: IDX_W])));
endmodule

// File: rtl/pal_status_rd.sv
module pal_status_rd #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              busy,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= {{(DATA_W-1){1'b0}}, busy};
  end

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/pal_update_port.sv
module pal_update_port #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [IDX_W-1:0]  vid_idx,
  output logic [DATA_W-1:0] vid_color
);
  logic              busy;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  pal_burst_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(cpu_wr_en), .wdata(cpu_wdata),
    .busy(busy), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  pal_color_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(vid_idx), .rdata(vid_color)
  );

  pal_status_rd #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .rd_en(cpu_rd_en), .busy(busy), .rdata(cpu_rdata)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy && cpu_rdata == '0));
endmodule

// File: tb/pal_update_port_tb.sv
module pal_update_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_rd_en = 1'b0;
  logic [15:0] cpu_rdata;
  logic [7:0]  vid_idx = '0;
  logic [15:0] vid_color;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [15:0] exp_mem [256];
  bit          m_busy = 1'b0;
  logic [7:0]  m_ptr  = '0;
  logic [7:0]  m_rem  = '0;

  pal_update_port u_dut (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
    .cpu_rd_en(cpu_rd_en), .cpu_rdata(cpu_rdata),
    .vid_idx(vid_idx), .vid_color(vid_color)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mk_hdr(input logic [7:0] idx, input logic [7:0] cnt);
    return {idx, cnt};
  endfunction

  function automatic logic [15:0] exp_status(input bit b);
    return {15'b0, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model update follows the requirements R2..R6
  task automatic cpu_write(input logic [15:0] w);
    @(negedge clk);
    cpu_wr_en = 1'b1;
    cpu_wdata = w;
    @(negedge clk);
    cpu_wr_en = 1'b0;
    if (!m_busy) begin
      m_ptr  = w[15:8];
      m_rem  = w[7:0];
      m_busy = (w[7:0] != 8'd0);
    end else begin
      exp_mem[m_ptr] = w;
      m_ptr  = m_ptr + 8'd1;
      m_rem  = m_rem - 8'd1;
      m_busy = (m_rem != 8'd0);
    end
  endtask

  task automatic status_check(input string req);
    @(negedge clk);
    cpu_rd_en = 1'b1;
    @(negedge clk);
    cpu_rd_en = 1'b0;
    check(cpu_rdata == exp_status(m_busy), req, cpu_rdata, exp_status(m_busy));
  endtask

  task automatic vid_check(input logic [7:0] idx, input string req);
    @(negedge clk);
    vid_idx = idx;
    @(negedge clk);
    check(vid_color == exp_mem[idx], req, vid_color, exp_mem[idx]);
  endtask

  task automatic dump_check(input string req);
    for (int i = 0; i < 256; i++) vid_check(8'(i), req);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd24681);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: idle after reset, first write is a header
    status_check("R1 reset status");
    cpu_write(mk_hdr(8'd0, 8'd2));
    status_check("R1 first write is header");

    // R2, R3: fill the whole table in two bursts
    cpu_write(16'h1111);
    cpu_write(16'h2222);
    status_check("R6 burst closed");
    cpu_write(mk_hdr(8'd2, 8'd254));
    for (int i = 2; i < 256; i++) cpu_write(16'($urandom));
    cpu_write(mk_hdr(8'd0, 8'd0));
    status_check("R5 zero count idle");
    dump_check("R3 sequential fill");

    // R4: wrap past entry 255
    cpu_write(mk_hdr(8'd253, 8'd5));
    for (int i = 0; i < 5; i++) cpu_write(16'hA000 + 16'(i));
    vid_check(8'd253, "R4 before wrap");
    vid_check(8'd255, "R4 last entry");
    vid_check(8'd0,   "R4 wrapped entry 0");
    vid_check(8'd1,   "R4 wrapped entry 1");
    vid_check(8'd2,   "R4 untouched after wrap");

    // R5: zero count header stores nothing, next write is header
    cpu_write(mk_hdr(8'd40, 8'd0));
    status_check("R5 zero count status");
    cpu_write(mk_hdr(8'd41, 8'd1));
    status_check("R5 next write is header");
    cpu_write(16'hBEEF);
    vid_check(8'd40, "R5 no store at zero-count index");
    vid_check(8'd41, "R5 store after new header");

    // R6: word after the burst is a header, not a color
    cpu_write(mk_hdr(8'd80, 8'd1));
    cpu_write(16'h0F0F);
    cpu_write(mk_hdr(8'd81, 8'd0));
    vid_check(8'd80, "R6 last counted word");
    vid_check(8'd81, "R6 header not stored");
    status_check("R6 idle after burst");

    // R7: status reads mid-burst do not disturb the burst
    cpu_write(mk_hdr(8'd100, 8'd3));
    status_check("R7 busy mid burst");
    cpu_write(16'h1234);
    status_check("R7 busy after first word");
    status_check("R7 repeat read");
    cpu_write(16'h5678);
    cpu_write(16'h9ABC);
    status_check("R7 idle after last word");
    vid_check(8'd100, "R7 word 0");
    vid_check(8'd101, "R7 word 1");
    vid_check(8'd102, "R7 word 2");

    // Random bursts with interleaved status reads, then full readback (R3, R8)
    for (int b = 0; b < 40; b++) begin
      logic [7:0] n;
      n = 8'($urandom_range(0, 24));
      cpu_write(mk_hdr(8'($urandom), n));
      for (int k = 0; k < int'(n); k++) begin
        cpu_write(16'($urandom));
        if ($urandom_range(0, 3) == 0) status_check("R7 random status");
      end
      status_check("R6 random burst end");
      if (b % 10 == 9) dump_check("R8 random readback");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule